// File: doc/BRIEF.md
# Page Read-Modify-Write Sequencer

This block changes selected bits of one block inside a page of an erase-before-write memory. In that memory only a whole page can be erased, and a block can be programmed only once after each erase. A bit change is therefore never made in place. The sequencer first copies all blocks of the addressed page into a local page buffer, folding the host's masked data into the target block as that block arrives. It then erases the page and programs every block back from the buffer in ascending order.

The host offers a request with a valid/ready handshake. The request carries a page address, a block index, 64 bits of new data and a 64-bit bit mask. The sequencer accepts it in a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from the next cycle until the write-back ends, which is the back-pressure rule: the host holds its request until it sees ready, and any request offered while ready is low is ignored. A one-cycle `done` pulse marks the end of each update.

The memory side is a plain command port. A command is a single-cycle `mem_cmd_valid` pulse with an opcode, a page, a block and write data, and it is issued only while `mem_busy` is low. The memory must raise `mem_busy` in the cycle after it accepts a command and hold it high for at least one cycle. Read data must be valid on `mem_rdata` in the first cycle `mem_busy` is low again.

Top module: `page_rmw_seq`

## Requirements
- R1: Out of reset, `req_ready` is 1, `mem_cmd_valid` is 0 and `done` is 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both high. From the next cycle `req_ready` stays 0 until the update ends. Requests offered while it is 0 change nothing in memory.
- R3: After acceptance the sequencer issues 32 read commands (opcode 2'b01), with block fields 0, 1, …, 31 in that order. Every command of the update carries the accepted page address on `mem_cmd_page`.
- R4: The block at the requested index is written back as (old & ~mask) | (data & mask). All other blocks are written back with exactly the value read.
- R5: After the 32nd read completes, one erase command (opcode 2'b10) is issued, and its block field is all zeros.
- R6: After the erase completes, 32 write commands (opcode 2'b11) are issued with block fields 0 … 31 ascending. This makes 65 commands per update, and no block is programmed twice without an erase in between.
- R7: A command is issued only while `mem_busy` is low and lasts one cycle. After each command the sequencer waits for `mem_busy` to fall before it issues the next one. While `mem_busy` stays high, no command is issued.
- R8: `done` is high for exactly one cycle, namely the cycle after the 32nd write completes (the cycle in which `mem_busy` is first seen low). `req_ready` returns to 1 in that same cycle.
- R9: An all-zero mask still runs the full sequence and leaves the page contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_page | input | 11 | Page to update |
| req_blk | input | 5 | Block within the page to modify |
| req_data | input | 64 | New bit values |
| req_mask | input | 64 | 1 = take the bit from req_data |
| done | output | 1 | One-cycle pulse at the end of an update |
| mem_cmd_valid | output | 1 | Command strobe to memory |
| mem_cmd_op | output | 2 | 01 read, 10 erase, 11 write, 00 when idle |
| mem_cmd_page | output | 11 | Page address of the command |
| mem_cmd_blk | output | 5 | Block address (zero for erase) |
| mem_cmd_wdata | output | 64 | Block data for write commands |
| mem_busy | input | 1 | Memory is executing a command |
| mem_rdata | input | 64 | Read data, valid when busy falls after a read |

## Verification
The merge is tried with several masks. A full mask shows that every bit is taken from the request. A mask on only the two edge bits (63 and 0) exposes a reversed or shifted bit order. An interleaved byte mask shows that the mask is applied per bit rather than per block. An all-zero mask shows that the page survives a full erase and rewrite unchanged. Target blocks 0, 31 and middle indices, on the highest and lowest page addresses, separate off-by-one errors in the block counter and in the target match. The same page is updated twice in a row to show that each write-back programs only freshly erased blocks. Directed runs hold `mem_busy` high to prove that no command escapes, and offer a second request mid-update to prove it is ignored.

// File: rtl/page_rmw_pkg.sv
package page_rmw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RD_ISS, S_RD_WAIT, S_ER_ISS, S_ER_WAIT, S_WR_ISS, S_WR_WAIT
  } seq_state_t;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_ERASE = 2'b10,
    OP_WRITE = 2'b11
  } mem_op_t;
endpackage

// File: rtl/rmw_page_buf.sv
module rmw_page_buf #(
  parameter int BLK_W   = 64,
  parameter int NUM_BLK = 32,
  parameter int BLK_AW  = 5
) (
  input  logic              clk,
  input  logic              cap_en,
  input  logic [BLK_AW-1:0] cap_idx,
  input  logic [BLK_W-1:0]  cap_data,
  input  logic [BLK_AW-1:0] tgt_idx,
  input  logic [BLK_W-1:0]  new_data,
  input  logic [BLK_W-1:0]  new_mask,
  input  logic [BLK_AW-1:0] rd_idx,
  output logic [BLK_W-1:0]  rd_data
);
  logic [BLK_W-1:0] store [NUM_BLK];
  logic [BLK_W-1:0] merged;

  // The target block is merged as it is captured, so no extra pass is needed.
  always_comb begin
    if (cap_idx == tgt_idx)
      merged = (cap_data & ~new_mask) | (new_data & new_mask);
    else
      merged = cap_data;
  end

  always_ff @(posedge clk) begin
    if (cap_en) store[cap_idx] <= merged;
  end

  assign rd_data = store[rd_idx];
endmodule

// File: rtl/rmw_seq_fsm.sv
module rmw_seq_fsm
  import page_rmw_pkg::*;
#(
  parameter int NUM_BLK = 32,
  parameter int BLK_AW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mem_busy,
  output logic              idle,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [BLK_AW-1:0] blk_idx,
  output logic              cap_en,
  output logic              done
);
  localparam logic [BLK_AW-1:0] LAST_IDX = BLK_AW'(NUM_BLK - 1);

  seq_state_t state, state_nx;
  logic [BLK_AW-1:0] cnt;
  logic last, step;

  assign last = (cnt == LAST_IDX);
  assign idle = (state == S_IDLE);
  assign step = !mem_busy && (state == S_RD_WAIT || state == S_WR_WAIT);

  always_comb begin
    state_nx  = state;
    cmd_valid = 1'b0;
    cmd_op    = OP_NONE;
    cap_en    = 1'b0;
    unique case (state)
      S_IDLE:    if (start) state_nx = S_RD_ISS;
      S_RD_ISS:  if (!mem_busy) begin
                   cmd_valid = 1'b1; cmd_op = OP_READ; state_nx = S_RD_WAIT;
                 end
      S_RD_WAIT: if (!mem_busy) begin
                   cap_en   = 1'b1;
                   state_nx = last ? S_ER_ISS : S_RD_ISS;
                 end
      S_ER_ISS:  if (!mem_busy) begin
                   cmd_valid = 1'b1; cmd_op = OP_ERASE; state_nx = S_ER_WAIT;
                 end
      S_ER_WAIT: if (!mem_busy) state_nx = S_WR_ISS;
      S_WR_ISS:  if (!mem_busy) begin
                   cmd_valid = 1'b1; cmd_op = OP_WRITE; state_nx = S_WR_WAIT;
                 end
      S_WR_WAIT: if (!mem_busy) state_nx = last ? S_IDLE : S_WR_ISS;
      default:   state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      state <= state_nx;
      done  <= (state == S_WR_WAIT) && !mem_busy && last;
      if (step) cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  assign blk_idx = cnt;

  assert_single_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle) |=> !idle);
endmodule

// File: rtl/page_rmw_seq.sv
module page_rmw_seq
  import page_rmw_pkg::*;
#(
  parameter int PAGE_AW = 11,
  parameter int NUM_BLK = 32,
  parameter int BLK_W   = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [PAGE_AW-1:0] req_page,
  input  logic [$clog2(NUM_BLK)-1:0] req_blk,
  input  logic [BLK_W-1:0]   req_data,
  input  logic [BLK_W-1:0]   req_mask,
  output logic               done,
  output logic               mem_cmd_valid,
  output logic [1:0]         mem_cmd_op,
  output logic [PAGE_AW-1:0] mem_cmd_page,
  output logic [$clog2(NUM_BLK)-1:0] mem_cmd_blk,
  output logic [BLK_W-1:0]   mem_cmd_wdata,
  input  logic               mem_busy,
  input  logic [BLK_W-1:0]   mem_rdata
);
  localparam int BLK_AW = $clog2(NUM_BLK);

  logic               accept, idle, cap_en;
  logic [BLK_AW-1:0]  blk_idx;
  logic [PAGE_AW-1:0] pg_q;
  logic [BLK_AW-1:0]  tgt_q;
  logic [BLK_W-1:0]   data_q, mask_q;

  assign req_ready = idle;
  assign accept    = req_valid && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q   <= '0;
      tgt_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else if (accept) begin
      pg_q   <= req_page;
      tgt_q  <= req_blk;
      data_q <= req_data;
      mask_q <= req_mask;
    end
  end

  rmw_seq_fsm #(.NUM_BLK(NUM_BLK), .BLK_AW(BLK_AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept), .mem_busy(mem_busy),
    .idle(idle), .cmd_valid(mem_cmd_valid), .cmd_op(mem_cmd_op),
    .blk_idx(blk_idx), .cap_en(cap_en), .done(done)
  );

  rmw_page_buf #(.BLK_W(BLK_W), .NUM_BLK(NUM_BLK), .BLK_AW(BLK_AW)) u_buf (
    .clk(clk), .cap_en(cap_en), .cap_idx(blk_idx), .cap_data(mem_rdata),
    .tgt_idx(tgt_q), .new_data(data_q), .new_mask(mask_q),
    .rd_idx(blk_idx), .rd_data(mem_cmd_wdata)
  );

  assign mem_cmd_page = pg_q;
  assign mem_cmd_blk  = blk_idx;

  assert_erase_blk_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && mem_cmd_op == OP_ERASE) |-> (mem_cmd_blk == '0));
  assert_page_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_cmd_page));
endmodule

// File: tb/page_rmw_seq_tb.sv
module page_rmw_seq_tb_top;
  localparam int LAT = 3;

  typedef struct packed {
    logic [10:0] pg;
    logic [4:0]  blk;
    logic [63:0] d;
    logic [63:0] m;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{11'h000, 5'd0,  64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    '{11'h7FF, 5'd31, 64'h0000_0000_0000_0000, 64'h8000_0000_0000_0001},
    '{11'h002, 5'd13, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0000},
    '{11'h001, 5'd7,  64'hAAAA_AAAA_AAAA_AAAA, 64'h00FF_00FF_00FF_00FF},
    '{11'h000, 5'd0,  64'h0000_0000_0000_0000, 64'hF0F0_F0F0_F0F0_F0F0},
    '{11'h7FF, 5'd16, 64'h5555_5555_5555_5555, 64'hFFFF_FFFF_0000_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, done;
  logic [10:0] req_page = '0;
  logic [4:0]  req_blk = '0;
  logic [63:0] req_data = '0, req_mask = '0;
  logic mem_cmd_valid, mem_busy;
  logic [1:0]  mem_cmd_op;
  logic [10:0] mem_cmd_page;
  logic [4:0]  mem_cmd_blk;
  logic [63:0] mem_cmd_wdata, mem_rdata;

  always #5 clk = ~clk;

  page_rmw_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .req_blk(req_blk), .req_data(req_data),
    .req_mask(req_mask), .done(done), .mem_cmd_valid(mem_cmd_valid),
    .mem_cmd_op(mem_cmd_op), .mem_cmd_page(mem_cmd_page),
    .mem_cmd_blk(mem_cmd_blk), .mem_cmd_wdata(mem_cmd_wdata),
    .mem_busy(mem_busy), .mem_rdata(mem_rdata)
  );

  // memory model: 4 pages selected by the low page bits
  logic [63:0] mem [4][32];
  logic        prog [4][32];
  logic [63:0] ref_mem [4][32];
  int  busy_cnt = 0, op_idx = 0, model_errs = 0, cmd_seen = 0;
  logic force_busy = 1'b0;
  logic [10:0] acc_page = '0;
  logic [63:0] rdata_q = '0;

  assign mem_busy  = (busy_cnt != 0) || force_busy;
  assign mem_rdata = rdata_q;

  function automatic logic [63:0] seed_word(int p, int b);
    return 64'h9E37_79B9_7F4A_7C15 * 64'(p * 32 + b + 1);
  endfunction

  initial begin
    for (int p = 0; p < 4; p++)
      for (int b = 0; b < 32; b++) begin
        mem[p][b] = seed_word(p, b);
        ref_mem[p][b] = seed_word(p, b);
        prog[p][b] = 1'b1;
      end
  end

  always @(posedge clk) begin
    if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (req_valid && req_ready) begin
      op_idx <= 0;
      acc_page <= req_page;
    end
    if (mem_cmd_valid) begin
      cmd_seen <= cmd_seen + 1;
      if (mem_busy) begin model_errs++; $display("model: command while busy"); end
      if (mem_cmd_page != acc_page) begin model_errs++; $display("model: page %h", mem_cmd_page); end
      if (op_idx < 32) begin
        if (mem_cmd_op != 2'b01 || mem_cmd_blk != 5'(op_idx)) begin
          model_errs++; $display("model: bad read step %0d", op_idx);
        end
      end else if (op_idx == 32) begin
        if (mem_cmd_op != 2'b10 || mem_cmd_blk != 5'd0) begin
          model_errs++; $display("model: bad erase step");
        end
      end else if (op_idx < 65) begin
        if (mem_cmd_op != 2'b11 || mem_cmd_blk != 5'(op_idx - 33)) begin
          model_errs++; $display("model: bad write step %0d", op_idx);
        end
      end else begin
        model_errs++; $display("model: extra command");
      end
      case (mem_cmd_op)
        2'b01: rdata_q <= mem[mem_cmd_page[1:0]][mem_cmd_blk];
        2'b10: for (int b = 0; b < 32; b++) begin
                 mem[mem_cmd_page[1:0]][b] <= '0;
                 prog[mem_cmd_page[1:0]][b] <= 1'b0;
               end
        2'b11: begin
                 if (prog[mem_cmd_page[1:0]][mem_cmd_blk]) begin
                   model_errs++; $display("model: block programmed twice");
                 end
                 mem[mem_cmd_page[1:0]][mem_cmd_blk] <= mem_cmd_wdata;
                 prog[mem_cmd_page[1:0]][mem_cmd_blk] <= 1'b1;
               end
        default: begin model_errs++; $display("model: no opcode"); end
      endcase
      op_idx <= op_idx + 1;
      busy_cnt <= LAT;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic launch(input vec_t v);
    int pi;
    @(negedge clk);
    req_page = v.pg; req_blk = v.blk; req_data = v.d; req_mask = v.m;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2", "ready after accept", 64'(req_ready), 64'd0);
    pi = int'(v.pg[1:0]);
    ref_mem[pi][v.blk] = (ref_mem[pi][v.blk] & ~v.m) | (v.d & v.m);
  endtask

  task automatic finish_req(input vec_t v, input string mtag);
    bit seen = 0;
    int errs0 = model_errs;
    int pi = int'(v.pg[1:0]);
    for (int i = 0; i < 4000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen, "R8", "done seen", 64'(seen), 64'd1);
    chk(req_ready == 1'b1, "R8", "ready with done", 64'(req_ready), 64'd1);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", 64'(done), 64'd0);
    chk(op_idx == 65, "R6", "command count", 64'(op_idx), 64'd65);
    chk(model_errs == errs0, "R3", "command order/page/erase field (R5 R7)",
        64'(model_errs - errs0), 64'd0);
    for (int b = 0; b < 32; b++) begin
      chk(mem[pi][b] == ref_mem[pi][b], mtag, $sformatf("block %0d", b),
          mem[pi][b], ref_mem[pi][b]);
      chk(prog[pi][b] == 1'b1, "R6", "block written back", 64'(prog[pi][b]), 64'd1);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R8", "watchdog expired", 64'd0, 64'd1);
    summary();
  end

  initial begin
    vec_t va, vb;
    int seen0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);
    chk(mem_cmd_valid == 1'b0, "R1", "reset cmd", 64'(mem_cmd_valid), 64'd0);
    chk(done == 1'b0, "R1", "reset done", 64'(done), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1 && mem_cmd_valid == 1'b0, "R1", "idle after reset",
        64'({req_ready, mem_cmd_valid}), 64'd2);

    for (int i = 0; i < 6; i++) begin
      launch(VECS[i]);
      finish_req(VECS[i], (VECS[i].m == 64'd0) ? "R9" : "R4");
    end

    // R2: a request offered mid-update is ignored
    va = '{11'h001, 5'd3, 64'h1111_2222_3333_4444, 64'hFFFF_0000_FFFF_0000};
    vb = '{11'h002, 5'd5, 64'hDEAD_BEEF_DEAD_BEEF, 64'hFFFF_FFFF_FFFF_FFFF};
    launch(va);
    repeat (40) @(negedge clk);
    req_page = vb.pg; req_blk = vb.blk; req_data = vb.d; req_mask = vb.m;
    req_valid = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R2", "ready low mid-update", 64'(req_ready), 64'd0);
    end
    req_valid = 1'b0;
    finish_req(va, "R4");
    for (int b = 0; b < 32; b++)
      chk(mem[2][b] == ref_mem[2][b], "R2", "ignored request page",
          mem[2][b], ref_mem[2][b]);

    // R7: no command while busy is held high
    force_busy = 1'b1;
    va = '{11'h7FF, 5'd1, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0000_0000_FFFF_FFFF};
    launch(va);
    seen0 = cmd_seen;
    repeat (20) begin
      @(negedge clk);
      chk(mem_cmd_valid == 1'b0, "R7", "cmd while busy", 64'(mem_cmd_valid), 64'd0);
    end
    chk(cmd_seen == seen0, "R7", "commands during busy", 64'(cmd_seen - seen0), 64'd0);
    force_busy = 1'b0;
    finish_req(va, "R4");

    summary();
  end
endmodule